// File: doc/BRIEF.md
# Triggered Event Packet Assembler

This block sequences the readout of a square matrix of self-triggering pixels. While idle it watches the trigger lines of every pixel. When one or more fire, it latches the pixel with the lowest index and raises a gate pulse for the time-to-digital front end. The gate is closed by the next rising edge of a slow reference clock (nominally 10 MHz). The measured interval is therefore the time left until that reference edge, which is at most one reference period.

Once the gate has closed, the block builds a fixed packet of twelve words and streams it out over a valid/ready handshake. The packet holds the hit address, the time measurement, a temperature reading and nine pixel energies. The energies are the hit pixel itself and then its surrounding 3x3 ring. All conversion results come through one shared read port, one request at a time. Converters and the analog chain sit outside the block. The reference clock is sampled in the system clock domain. `rst_n` is expected to arrive already release-synchronised.

Top module: `evpkt_assembler`

## Requirements
- R1: When the block is idle and any `hit_i` bit is sampled high at a clock edge, `gate_o` is high from that edge onward.
- R2: An open gate closes at the first clock edge at which `ref_clk_i` is sampled high after being sampled low in the cycle before. A reference rise seen at the edge that opens the gate does not close it.
- R3: Each accepted trigger produces exactly twelve output words. `pkt_last_o` is high on the twelfth word and low on the other eleven.
- R4: Word 0 is the hit pixel index, row*DIM+column, zero-extended to the word width.
- R5: Word 1 is the result of a read with `rd_sel_o`=0 (time). Word 2 is the result of a read with `rd_sel_o`=1 (temperature). `rd_sel_o` and `rd_chan_o` stay stable while `rd_req_o` is high and `rd_ack_i` is low.
- R6: Word 3 is the energy of the hit pixel. Words 4 to 11 are the energies of its neighbours in this order: row above (left, centre, right), same row (left, right), row below (left, centre, right). Each energy is read with `rd_sel_o`=2 and `rd_chan_o`=row*DIM+column.
- R7: A neighbour that lies outside the matrix is sent as 0x000, and no bus read is made for it.
- R8: Triggers that arrive between the opening of a gate and the acceptance of the twelfth word are ignored. A new gate opens only after that word has been accepted.
- R9: When several pixels trigger in the same cycle, the lowest index is taken.
- R10: While `pkt_valid_o` is high and `pkt_ready_i` is low, `pkt_valid_o`, `pkt_data_o` and `pkt_last_o` hold their values.
- R11: During reset, `gate_o`, `rd_req_o` and `pkt_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit_i | input | DIM*DIM | Per-pixel trigger lines, bit i = pixel i |
| ref_clk_i | input | 1 | Reference clock that closes the gate, sampled on clk |
| gate_o | output | 1 | Gate pulse to the time-to-digital front end |
| rd_req_o | output | 1 | Shared conversion read request |
| rd_sel_o | output | 2 | Read source: 0 time, 1 temperature, 2 pixel energy |
| rd_chan_o | output | clog2(DIM*DIM) | Pixel index for an energy read |
| rd_ack_i | input | 1 | Read result valid; completes the request |
| rd_data_i | input | WORD_W | Read result |
| pkt_valid_o | output | 1 | Output word valid |
| pkt_ready_i | input | 1 | Downstream accepts the word |
| pkt_data_o | output | WORD_W | Output word |
| pkt_last_o | output | 1 | Marks the twelfth word of a packet |

## Verification
The gate is due one cycle after a trigger is sampled in the idle state. It closes in the cycle that follows the edge at which the reference clock is first seen high. The bench model steps once per clock and compares `gate_o` in every cycle, so a gate that opens or closes one cycle early or late is reported. Output words have no fixed latency, because they depend on read-acknowledge delay and back-pressure. Each word is therefore compared at the edge where valid and ready are both high, against a queue that the model built when the trigger was accepted. Any cycle that follows a stalled word is checked for unchanged valid, data and last.

// File: rtl/evpkt_pkg.sv
package evpkt_pkg;
  localparam int PKT_WORDS   = 12;
  localparam int SLOT_W      = 4;
  localparam int CENTRE_SLOT = 3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_GATE, ST_LOAD, ST_FETCH, ST_SEND
  } seq_state_e;

  typedef enum logic [1:0] {
    SRC_TIME  = 2'd0,
    SRC_TEMP  = 2'd1,
    SRC_PIXEL = 2'd2,
    SRC_NONE  = 2'd3
  } rd_src_e;
endpackage

// File: rtl/evpkt_hit_pick.sv
module evpkt_hit_pick #(
  parameter int NPIX  = 16,
  parameter int IDX_W = 4
) (
  input  logic [NPIX-1:0]  hit_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  // scan from the top so the lowest set bit is the last one written
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = NPIX - 1; i >= 0; i--) begin
      if (hit_i[i]) begin
        any_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/evpkt_ref_edge.sv
module evpkt_ref_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_i,
  output logic rise_o
);
  logic ref_q;
  logic ref_d;

  assign ref_d = ref_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_q <= 1'b0;
    else        ref_q <= ref_d;
  end

  assign rise_o = ref_i & ~ref_q;
endmodule

// File: rtl/evpkt_slot_map.sv
module evpkt_slot_map
  import evpkt_pkg::*;
#(
  parameter int DIM   = 4,
  parameter int IDX_W = 4
) (
  input  logic [IDX_W-1:0]  addr_i,
  input  logic [SLOT_W-1:0] slot_i,
  output logic              fetch_o,
  output logic [1:0]        src_o,
  output logic [IDX_W-1:0]  chan_o
);
  // slot 3 is the centre (ring position 4); slots 4..11 walk the ring
  // positions 0..8 in raster order, skipping position 4
  always_comb begin
    int pos;
    int rr;
    int cc;
    pos = 4;
    if (int'(slot_i) > CENTRE_SLOT) begin
      pos = int'(slot_i) - 4;
      if (pos >= 4) pos = pos + 1;
    end
    rr = int'(addr_i) / DIM + pos / 3 - 1;
    cc = int'(addr_i) % DIM + pos % 3 - 1;

    fetch_o = 1'b0;
    src_o   = SRC_NONE;
    chan_o  = '0;
    if (slot_i == SLOT_W'(1)) begin
      fetch_o = 1'b1;
      src_o   = SRC_TIME;
    end else if (slot_i == SLOT_W'(2)) begin
      fetch_o = 1'b1;
      src_o   = SRC_TEMP;
    end else if (int'(slot_i) >= CENTRE_SLOT &&
                 rr >= 0 && rr < DIM && cc >= 0 && cc < DIM) begin
      fetch_o = 1'b1;
      src_o   = SRC_PIXEL;
      chan_o  = IDX_W'(rr * DIM + cc);
    end
  end
endmodule

// File: rtl/evpkt_assembler.sv
module evpkt_assembler
  import evpkt_pkg::*;
#(
  parameter  int DIM    = 4,
  parameter  int WORD_W = 10,
  localparam int NPIX   = DIM * DIM,
  localparam int IDX_W  = (NPIX > 1) ? $clog2(NPIX) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPIX-1:0]   hit_i,
  input  logic              ref_clk_i,
  output logic              gate_o,
  output logic              rd_req_o,
  output logic [1:0]        rd_sel_o,
  output logic [IDX_W-1:0]  rd_chan_o,
  input  logic              rd_ack_i,
  input  logic [WORD_W-1:0] rd_data_i,
  output logic              pkt_valid_o,
  input  logic              pkt_ready_i,
  output logic [WORD_W-1:0] pkt_data_o,
  output logic              pkt_last_o
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(PKT_WORDS - 1);

  seq_state_e        state_q, state_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [IDX_W-1:0]  addr_q, addr_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic              gate_q, gate_d;
  logic              addr_en, word_en;

  logic              hit_any;
  logic [IDX_W-1:0]  pick_idx;
  logic              ref_rise;
  logic              map_fetch;
  logic [1:0]        map_src;
  logic [IDX_W-1:0]  map_chan;

  evpkt_hit_pick #(.NPIX(NPIX), .IDX_W(IDX_W)) u_pick (
    .hit_i (hit_i),
    .any_o (hit_any),
    .idx_o (pick_idx)
  );

  evpkt_ref_edge u_ref (
    .clk    (clk),
    .rst_n  (rst_n),
    .ref_i  (ref_clk_i),
    .rise_o (ref_rise)
  );

  evpkt_slot_map #(.DIM(DIM), .IDX_W(IDX_W)) u_map (
    .addr_i  (addr_q),
    .slot_i  (slot_q),
    .fetch_o (map_fetch),
    .src_o   (map_src),
    .chan_o  (map_chan)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    slot_d  = slot_q;
    addr_d  = addr_q;
    word_d  = word_q;
    gate_d  = gate_q;
    addr_en = 1'b0;
    word_en = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (hit_any) begin
          addr_d  = pick_idx;
          addr_en = 1'b1;
          gate_d  = 1'b1;
          state_d = ST_GATE;
        end
      end
      ST_GATE: begin
        if (ref_rise) begin
          gate_d  = 1'b0;
          slot_d  = '0;
          state_d = ST_LOAD;
        end
      end
      ST_LOAD: begin
        if (map_fetch) begin
          state_d = ST_FETCH;
        end else begin
          word_d  = (slot_q == '0) ? WORD_W'(addr_q) : '0;
          word_en = 1'b1;
          state_d = ST_SEND;
        end
      end
      ST_FETCH: begin
        if (rd_ack_i) begin
          word_d  = rd_data_i;
          word_en = 1'b1;
          state_d = ST_SEND;
        end
      end
      ST_SEND: begin
        if (pkt_ready_i) begin
          if (slot_q == LAST_SLOT) begin
            state_d = ST_IDLE;
          end else begin
            slot_d  = slot_q + SLOT_W'(1);
            state_d = ST_LOAD;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      slot_q  <= '0;
      gate_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      slot_q  <= slot_d;
      gate_q  <= gate_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word_q <= '0;
    else if (word_en) word_q <= word_d;
  end

  assign gate_o      = gate_q;
  assign rd_req_o    = (state_q == ST_FETCH);
  assign rd_sel_o    = map_src;
  assign rd_chan_o   = map_chan;
  assign pkt_valid_o = (state_q == ST_SEND);
  assign pkt_data_o  = word_q;
  assign pkt_last_o  = (state_q == ST_SEND) && (slot_q == LAST_SLOT);

  // R1 R8
  gate_open_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_o) |-> $past(state_q == ST_IDLE && !pkt_valid_o && !rd_req_o));

  // R2
  gate_close_on_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gate_o) |-> $past(ref_clk_i) && !$past(ref_clk_i, 2));

  // R8
  gate_excl_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate_o |-> !pkt_valid_o && !rd_req_o);

  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid_o && !pkt_ready_i |=>
      pkt_valid_o && $stable(pkt_data_o) && $stable(pkt_last_o));

  // R5
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o && !rd_ack_i |=> rd_req_o && $stable(rd_sel_o) && $stable(rd_chan_o));

  // R9
  lowest_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_any |-> hit_i[pick_idx] &&
      ((hit_i & ((NPIX'(1) << pick_idx) - NPIX'(1))) == {NPIX{1'b0}}));
endmodule

// File: tb/test_evpkt_assembler.sv
module test_evpkt_assembler;
  localparam int DIM    = 4;
  localparam int WORD_W = 10;
  localparam int NPIX   = DIM * DIM;
  localparam int IDX_W  = $clog2(NPIX);
  localparam int LIMIT  = 100000;
  localparam int NPKT   = 30;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NPIX-1:0]   hit = '0;
  logic              ref_clk = 1'b0;
  logic              gate_o;
  logic              rd_req_o;
  logic [1:0]        rd_sel_o;
  logic [IDX_W-1:0]  rd_chan_o;
  logic              rd_ack = 1'b0;
  logic [WORD_W-1:0] rd_data = '0;
  logic              pkt_valid_o;
  logic              pkt_ready = 1'b0;
  logic [WORD_W-1:0] pkt_data_o;
  logic              pkt_last_o;

  always #2.5 clk = ~clk;

  evpkt_assembler #(.DIM(DIM), .WORD_W(WORD_W)) i_evpkt_assembler (
    .clk(clk), .rst_n(rst_n), .hit_i(hit), .ref_clk_i(ref_clk),
    .gate_o(gate_o), .rd_req_o(rd_req_o), .rd_sel_o(rd_sel_o),
    .rd_chan_o(rd_chan_o), .rd_ack_i(rd_ack), .rd_data_i(rd_data),
    .pkt_valid_o(pkt_valid_o), .pkt_ready_i(pkt_ready),
    .pkt_data_o(pkt_data_o), .pkt_last_o(pkt_last_o)
  );

  int n_cmp = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [WORD_W-1:0] energy(input int chan, input int seed);
    return 10'h200 | WORD_W'((chan * 13 + seed) & 'h1FF);
  endfunction

  // reference model state
  int               m_st = 0;            // 0 idle, 1 gate open, 2 packet in flight
  bit               m_gate = 1'b0;
  logic [WORD_W-1:0] exp_q[$];
  int               wcnt = 0;
  int               pkts = 0;
  int               seed = 0;
  logic [WORD_W-1:0] tdc_val = '0;
  logic [WORD_W-1:0] temp_val = '0;
  logic [NPIX-1:0]  h_prev = '0;
  bit               ref_prev = 1'b0;
  bit               ref_pp = 1'b0;
  bit               hs_last_prev = 1'b0;
  bit               v_prev = 1'b0;
  bit               rdy_prev = 1'b0;
  bit               l_prev = 1'b0;
  logic [WORD_W-1:0] d_prev = '0;
  int               dly = 0;
  int               cyc = 0;
  int               dir_i = 0;
  int               gap = 0;
  logic [NPIX-1:0]  dir_mask[7] = '{16'h0001, 16'h8000, 16'h0004, 16'h0020,
                                   16'h0420, 16'h1008, 16'h0400};

  task automatic build(input int a);
    int r;
    int c;
    r = a / DIM;
    c = a % DIM;
    exp_q.push_back(WORD_W'(a));
    exp_q.push_back(tdc_val);
    exp_q.push_back(temp_val);
    exp_q.push_back(energy(a, seed));
    for (int dr = -1; dr <= 1; dr++)
      for (int dc = -1; dc <= 1; dc++)
        if (!(dr == 0 && dc == 0)) begin
          if (r + dr >= 0 && r + dr < DIM && c + dc >= 0 && c + dc < DIM)
            exp_q.push_back(energy((r + dr) * DIM + c + dc, seed));
          else
            exp_q.push_back('0);
        end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      bit old_gate;
      bit hs;
      logic [WORD_W-1:0] e;
      cyc++;
      ref_pp   = ref_prev;
      ref_prev = ref_clk;
      h_prev   = hit;
      old_gate = m_gate;

      // model step for the edge just past
      if (m_st == 0 && h_prev != '0) begin
        int low;
        low = 0;
        for (int i = NPIX - 1; i >= 0; i--) if (h_prev[i]) low = i;
        pkts++;
        seed     = $urandom_range(0, 511);
        tdc_val  = WORD_W'($urandom_range(0, 1023));
        temp_val = WORD_W'($urandom_range(0, 1023));
        build(low);
        m_gate = 1'b1;
        m_st   = 1;
      end else if (m_st == 1 && ref_prev && !ref_pp) begin
        m_gate = 1'b0;
        m_st   = 2;
      end else if (m_st == 2 && hs_last_prev) begin
        m_st = 0;
      end

      if (m_gate && !old_gate)
        chk(gate_o == m_gate, "R1", "gate opening", int'(gate_o), int'(m_gate));
      else if (!m_gate && old_gate)
        chk(gate_o == m_gate, "R2", "gate closing", int'(gate_o), int'(m_gate));
      else
        chk(gate_o == m_gate, "R8", "gate level", int'(gate_o), int'(m_gate));

      if (v_prev && !rdy_prev) begin
        chk(pkt_valid_o, "R10", "valid held", int'(pkt_valid_o), 1);
        chk(pkt_data_o == d_prev && pkt_last_o == l_prev, "R10", "data held",
            int'(pkt_data_o), int'(d_prev));
      end

      // drive inputs for the next edge
      ref_clk   = ((cyc / 10) % 2) == 1;
      pkt_ready = ($urandom_range(0, 3) != 0);
      hit       = '0;
      if (dir_i < 7) begin
        if (m_st == 0) begin
          gap++;
          if (gap >= 3) begin
            hit = dir_mask[dir_i];
            dir_i++;
            gap = 0;
          end
        end
      end else if ($urandom_range(0, 5) == 0) begin
        hit = NPIX'($urandom) & NPIX'($urandom);
      end

      if (rd_ack) begin
        rd_ack = 1'b0;
      end else if (rd_req_o) begin
        if (dly == 0) begin
          rd_ack = 1'b1;
          case (rd_sel_o)
            2'd0:    rd_data = tdc_val;
            2'd1:    rd_data = temp_val;
            2'd2:    rd_data = energy(int'(rd_chan_o), seed);
            default: rd_data = 10'h3FF;
          endcase
          dly = 2;
        end else begin
          dly--;
        end
      end

      // handshake at the coming edge
      hs = pkt_valid_o && pkt_ready;
      hs_last_prev = 1'b0;
      if (hs) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3 R8", "unexpected word", int'(pkt_data_o), 0);
        end else begin
          e = exp_q.pop_front();
          if (wcnt == 0)
            chk(pkt_data_o == e, "R4 R9", "address word", int'(pkt_data_o), int'(e));
          else if (wcnt < 3)
            chk(pkt_data_o == e, "R5", "time/temp word", int'(pkt_data_o), int'(e));
          else
            chk(pkt_data_o == e, "R6 R7", "energy word", int'(pkt_data_o), int'(e));
          chk(pkt_last_o == (wcnt == 11), "R3", "last flag", int'(pkt_last_o),
              int'(wcnt == 11));
          hs_last_prev = (wcnt == 11);
          wcnt = (wcnt == 11) ? 0 : wcnt + 1;
        end
      end
      v_prev   = pkt_valid_o;
      rdy_prev = pkt_ready;
      d_prev   = pkt_data_o;
      l_prev   = pkt_last_o;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!gate_o, "R11", "gate in reset", int'(gate_o), 0);
    chk(!pkt_valid_o, "R11", "valid in reset", int'(pkt_valid_o), 0);
    chk(!rd_req_o, "R11", "request in reset", int'(rd_req_o), 0);
    @(posedge clk);
    #1 rst_n = 1'b1;
    while (!(pkts >= NPKT && m_st == 0 && exp_q.size() == 0) && cyc < LIMIT)
      @(negedge clk);
    if (cyc >= LIMIT) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual %0d packets expected %0d", pkts, NPKT);
    end
    chk(exp_q.size() == 0, "R3", "words outstanding", exp_q.size(), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule